// File: doc/BRIEF.md
# Interval Timer Host Register Interface

This block is the byte-wide register front end of a three-channel programmable interval timer. A host reaches it through a 2-bit address with separate write and read strobes. Address 3 takes control words. Addresses 0 to 2 are the data ports of the three channels. The block keeps the programming state of each channel: access mode, counting mode and BCD flag. It orders the low and high bytes of 16-bit values across successive byte accesses. When a full count value has been written, it emits a one-cycle load pulse with that 16-bit value.

The counters themselves live outside this block. Each channel supplies its live 16-bit count and its output bit. The block can freeze either of these for the host, in one of two ways. A counter-latch control word freezes the count of one channel. A read-back control word can freeze the count, the status, or both, for any set of channels at once. A frozen value stays in place until the host reads it, and a second request does not overwrite it before then. Read data is registered.

Top module: `tmr_regif`

## Requirements
- R1: Address 3 accepts control words and never produces a load pulse. A read at address 3 returns 8'h00 and changes no state. Addresses 0, 1 and 2 are the data ports of channels 0, 1 and 2.
- R2: A control word carries the channel in bits 7:6, the access code in bits 5:4, the counting mode in bits 3:1 and the BCD flag in bit 0. Access code 1 is low byte only, 2 is high byte only and 3 is low then high. A nonzero access code stores the three fields for the selected channel and restarts both its read and its write byte order at the low byte.
- R3: With access code 3, the first data write is held and gives no load. The second write produces a load pulse with value {second byte, held byte}. The pulse is high for exactly the one cycle after the write strobe's clock edge.
- R4: With access code 1, a data write loads {8'h00, data}. With access code 2, a data write loads {data, 8'h00}. Each such write gives one load pulse.
- R5: With no latch pending, reads return the live count. Code 1 always returns the low byte and code 2 always returns the high byte. Code 3 alternates low, high, low, and so on.
- R6: A control word with access code 0 captures the live count of the selected channel at that clock edge, tagged with the channel's current access code. Reads then return the captured count: code 1 returns its low byte and code 2 its high byte, each in one read, and code 3 returns the low byte and then the high byte. After that, reads return the live count again.
- R7: While a captured count is unread, a further count capture for that channel is ignored. While a captured status is unread, a further status capture for that channel is ignored.
- R8: A control word with channel field 3 is a read-back. Bit c+1 selects channel c. Bit 5 low requests a count capture and bit 4 low requests a status capture for every selected channel.
- R9: The captured status byte is {output bit, 1'b0, access code, counting mode, BCD flag}. A pending status is returned ahead of a pending count and is cleared by that one read.
- R10: rdata changes only at the clock edge where the read strobe is sampled, and holds its value in every other cycle.
- R11: After reset, no latch is pending, every channel uses access code 3 with counting mode 3 and BCD flag 0, both byte orders start at the low byte, rdata is 8'h00, and no load pulse is active.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | 2 | Register select: 0 to 2 are channel data ports, 3 is control |
| wr_en | input | 1 | Write strobe, sampled on the rising edge |
| rd_en | input | 1 | Read strobe, sampled on the rising edge |
| wdata | input | 8 | Write data byte |
| rdata | output | 8 | Registered read data byte |
| live_count | input | 48 | Live 16-bit count of each channel, channel c at bits 16c+15:16c |
| chan_out | input | 3 | Output bit of each channel |
| load_pulse | output | 3 | One-cycle count load strobe, one bit per channel |
| load_value | output | 48 | 16-bit load value of each channel, channel c at bits 16c+15:16c |

## Verification
Each result is registered once. A read byte is due in rdata one cycle after the clock edge that samples the read strobe, and a load pulse and its value are due in that same cycle after the write edge. Latch and byte-order state changes at the strobe edge itself, so the next access already sees it. The bench drives every strobe on a falling edge and holds it for one rising edge. It samples outputs on the following falling edge, where both kinds of result have settled. Its reference model advances at that same point and captures the live counts that are driven across the sampling edge.

// File: rtl/tmr_pkg.sv
// Shared definitions for the interval timer register interface.
// Assumes one byte of host data and two-byte counts.
package tmr_pkg;
    localparam int DATA_W = 8;
    localparam int CNT_W  = 2 * DATA_W;

    // Access code; the zero value doubles as "nothing latched"
    typedef enum logic [1:0] {
        ACC_NONE = 2'd0,
        ACC_LO   = 2'd1,
        ACC_HI   = 2'd2,
        ACC_WORD = 2'd3
    } acc_e;

    localparam logic [1:0] CTRL_ADDR = 2'd3;
    localparam logic [1:0] RB_SEL    = 2'd3;
    localparam logic [2:0] RST_MODE  = 3'd3;
endpackage

// File: rtl/tmr_ctrl_decode.sv
// Decodes host strobes into per-channel commands: configuration
// writes, count and status capture requests, data writes and data
// reads. Purely combinational. Assumes NUM_CH <= 3.
module tmr_ctrl_decode
    import tmr_pkg::*;
#(
    parameter int NUM_CH = 3
) (
    input  logic [1:0]        addr,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [3:0]        ctrl_hi,   // control word bits 7:4
    input  logic [NUM_CH:1]   rb_mask,   // read-back channel select bits
    output logic [NUM_CH-1:0] cfg_we,
    output logic [NUM_CH-1:0] cnt_req,
    output logic [NUM_CH-1:0] sts_req,
    output logic [NUM_CH-1:0] data_we,
    output logic [NUM_CH-1:0] data_re
);
    logic       ctrl_wr;
    logic [1:0] sel;
    logic [1:0] acc;
    logic       is_rb;

    // Split control word fields
    always_comb begin
        ctrl_wr = wr_en && (addr == CTRL_ADDR);
        sel     = ctrl_hi[3:2];
        acc     = ctrl_hi[1:0];
        is_rb   = (sel == RB_SEL);
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic hit;
        // Per-channel command strobes
        always_comb begin
            hit        = ctrl_wr && !is_rb && (sel == 2'(c));
            cfg_we[c]  = hit && (acc != 2'd0);
            cnt_req[c] = (hit && (acc == 2'd0))
                       || (ctrl_wr && is_rb && rb_mask[c+1] && !ctrl_hi[1]);
            sts_req[c] = ctrl_wr && is_rb && rb_mask[c+1] && !ctrl_hi[0];
            data_we[c] = wr_en && (addr == 2'(c));
            data_re[c] = rd_en && (addr == 2'(c));
        end
    end
endmodule

// File: rtl/tmr_chan_regs.sv
// Register state of one timer channel: programming fields, byte
// order of reads and writes, captured count and status, and the
// registered load strobe. Assumes at most one strobe per cycle
// addresses this channel's data port or its control word.
module tmr_chan_regs
    import tmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_acc,
    input  logic [2:0]        cfg_mode,
    input  logic              cfg_bcd,
    input  logic              cnt_req,
    input  logic              sts_req,
    input  logic              data_we,
    input  logic              data_re,
    input  logic [DATA_W-1:0] wdata,
    input  logic [CNT_W-1:0]  live,
    input  logic              out_bit,
    output logic [DATA_W-1:0] rd_byte,
    output logic              load_pulse,
    output logic [CNT_W-1:0]  load_value
);
    acc_e              acc;
    logic [2:0]        mode;
    logic              bcd;
    logic              wr_hi;
    logic              rd_hi;
    logic [DATA_W-1:0] hold;
    acc_e              clat;
    logic [CNT_W-1:0]  lcnt;
    logic              spend;
    logic [DATA_W-1:0] sts;

    // Byte offered to the read port, by priority
    always_comb begin
        if (spend) begin
            rd_byte = sts;
        end else if (clat != ACC_NONE) begin
            rd_byte = (clat == ACC_HI) ? lcnt[CNT_W-1:DATA_W] : lcnt[DATA_W-1:0];
        end else begin
            case (acc)
                ACC_HI:   rd_byte = live[CNT_W-1:DATA_W];
                ACC_WORD: rd_byte = rd_hi ? live[CNT_W-1:DATA_W] : live[DATA_W-1:0];
                default:  rd_byte = live[DATA_W-1:0];
            endcase
        end
    end

    // Channel state update on every strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc        <= ACC_WORD;
            mode       <= RST_MODE;
            bcd        <= 1'b0;
            wr_hi      <= 1'b0;
            rd_hi      <= 1'b0;
            hold       <= '0;
            clat       <= ACC_NONE;
            lcnt       <= '0;
            spend      <= 1'b0;
            sts        <= '0;
            load_pulse <= 1'b0;
            load_value <= '0;
        end else begin
            load_pulse <= 1'b0;
            if (data_re) begin
                if (spend) begin
                    spend <= 1'b0;
                end else if (clat == ACC_WORD) begin
                    clat <= ACC_HI;
                end else if (clat != ACC_NONE) begin
                    clat <= ACC_NONE;
                end else if (acc == ACC_WORD) begin
                    rd_hi <= !rd_hi;
                end
            end
            if (data_we) begin
                case (acc)
                    ACC_LO: begin
                        load_pulse <= 1'b1;
                        load_value <= {{DATA_W{1'b0}}, wdata};
                    end
                    ACC_HI: begin
                        load_pulse <= 1'b1;
                        load_value <= {wdata, {DATA_W{1'b0}}};
                    end
                    ACC_WORD: begin
                        if (wr_hi) begin
                            load_pulse <= 1'b1;
                            load_value <= {wdata, hold};
                        end else begin
                            hold <= wdata;
                        end
                        wr_hi <= !wr_hi;
                    end
                    default: ;
                endcase
            end
            if (cnt_req && (clat == ACC_NONE)) begin
                lcnt <= live;
                clat <= acc;
            end
            if (sts_req && !spend) begin
                sts   <= {out_bit, 1'b0, acc, mode, bcd};
                spend <= 1'b1;
            end
            if (cfg_we) begin
                acc   <= acc_e'(cfg_acc);
                mode  <= cfg_mode;
                bcd   <= cfg_bcd;
                wr_hi <= 1'b0;
                rd_hi <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/tmr_rd_mux.sv
// Selects the read byte of the addressed channel and registers it
// on a read strobe. The control address reads as zero.
module tmr_rd_mux
    import tmr_pkg::*;
#(
    parameter int NUM_CH = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [1:0]               addr,
    input  logic                     rd_en,
    input  logic [NUM_CH*DATA_W-1:0] chan_bytes,
    output logic [DATA_W-1:0]        rdata
);
    logic [DATA_W-1:0] sel_byte;

    // Pick the addressed channel's byte
    always_comb begin
        sel_byte = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            if (addr == 2'(c)) sel_byte = chan_bytes[c*DATA_W +: DATA_W];
        end
    end

    // Register read data only on a read strobe
    always_ff @(posedge clk) begin
        if (!rst_n)     rdata <= '0;
        else if (rd_en) rdata <= sel_byte;
    end
endmodule

// File: rtl/tmr_regif.sv
// Top of the interval timer host register interface. Wires the
// decoder, one register set per channel and the read data register.
// Assumes the host never asserts both strobes in the same cycle.
module tmr_regif
    import tmr_pkg::*;
#(
    parameter int NUM_CH = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [1:0]              addr,
    input  logic                    wr_en,
    input  logic                    rd_en,
    input  logic [DATA_W-1:0]       wdata,
    output logic [DATA_W-1:0]       rdata,
    input  logic [NUM_CH*CNT_W-1:0] live_count,
    input  logic [NUM_CH-1:0]       chan_out,
    output logic [NUM_CH-1:0]       load_pulse,
    output logic [NUM_CH*CNT_W-1:0] load_value
);
    logic [NUM_CH-1:0]        cfg_we;
    logic [NUM_CH-1:0]        cnt_req;
    logic [NUM_CH-1:0]        sts_req;
    logic [NUM_CH-1:0]        data_we;
    logic [NUM_CH-1:0]        data_re;
    logic [NUM_CH*DATA_W-1:0] chan_bytes;

    tmr_ctrl_decode #(.NUM_CH(NUM_CH)) u_dec (
        .addr    (addr),
        .wr_en   (wr_en),
        .rd_en   (rd_en),
        .ctrl_hi (wdata[7:4]),
        .rb_mask (wdata[NUM_CH:1]),
        .cfg_we  (cfg_we),
        .cnt_req (cnt_req),
        .sts_req (sts_req),
        .data_we (data_we),
        .data_re (data_re)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
        tmr_chan_regs u_chan (
            .clk        (clk),
            .rst_n      (rst_n),
            .cfg_we     (cfg_we[c]),
            .cfg_acc    (wdata[5:4]),
            .cfg_mode   (wdata[3:1]),
            .cfg_bcd    (wdata[0]),
            .cnt_req    (cnt_req[c]),
            .sts_req    (sts_req[c]),
            .data_we    (data_we[c]),
            .data_re    (data_re[c]),
            .wdata      (wdata),
            .live       (live_count[c*CNT_W +: CNT_W]),
            .out_bit    (chan_out[c]),
            .rd_byte    (chan_bytes[c*DATA_W +: DATA_W]),
            .load_pulse (load_pulse[c]),
            .load_value (load_value[c*CNT_W +: CNT_W])
        );
    end

    tmr_rd_mux #(.NUM_CH(NUM_CH)) u_rd (
        .clk        (clk),
        .rst_n      (rst_n),
        .addr       (addr),
        .rd_en      (rd_en),
        .chan_bytes (chan_bytes),
        .rdata      (rdata)
    );
endmodule

// File: rtl/tmr_regif_chk.sv
// Port-level protocol checks for tmr_regif, attached by bind.
module tmr_regif_chk
    import tmr_pkg::*;
#(
    parameter int NUM_CH = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        addr,
    input logic              wr_en,
    input logic              rd_en,
    input logic [DATA_W-1:0] rdata,
    input logic [NUM_CH-1:0] load_pulse
);
    // R1: control writes never load a count
    p_ctrl_no_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == CTRL_ADDR) |=> (load_pulse == '0));

    // R1: a read at the control address returns zero
    p_ctrl_read_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == CTRL_ADDR) |=> (rdata == '0));

    // R10: read data holds without a read strobe
    p_rdata_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rdata));

    // R3: at most one channel loads per cycle
    p_load_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(load_pulse));

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        // R3: a load follows a write to that channel's data port
        p_load_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
            load_pulse[c] |-> $past(wr_en && addr == 2'(c)));

        // R3: the load pulse lasts a single cycle
        p_load_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (load_pulse[c] && !(wr_en && addr == 2'(c))) |=> !load_pulse[c]);
    end
endmodule

bind tmr_regif tmr_regif_chk #(.NUM_CH(NUM_CH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .addr       (addr),
    .wr_en      (wr_en),
    .rd_en      (rd_en),
    .rdata      (rdata),
    .load_pulse (load_pulse)
);

// File: tb/tmr_regif_bench.sv
`timescale 1ns/1ps
module tmr_regif_bench;
    localparam int NCH = 3;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [1:0]    addr;
    logic          wr_en, rd_en;
    logic [7:0]    wdata, rdata;
    logic [47:0]   live_count;
    logic [2:0]    chan_out;
    logic [2:0]    load_pulse;
    logic [47:0]   load_value;

    always #10 clk = ~clk;

    tmr_regif #(.NUM_CH(NCH)) u_tmr_regif (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
        .wdata(wdata), .rdata(rdata), .live_count(live_count),
        .chan_out(chan_out), .load_pulse(load_pulse), .load_value(load_value)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // Reference model state per channel
    logic [1:0]  m_acc  [NCH];
    logic [2:0]  m_mode [NCH];
    logic        m_bcd  [NCH];
    logic        m_wrhi [NCH];
    logic        m_rdhi [NCH];
    logic [7:0]  m_hold [NCH];
    logic [1:0]  m_clat [NCH];
    logic [15:0] m_lcnt [NCH];
    logic        m_spend[NCH];
    logic [7:0]  m_sts  [NCH];

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] live_of(int c);
        return live_count[c*16 +: 16];
    endfunction

    task automatic model_reset();
        for (int c = 0; c < NCH; c++) begin
            m_acc[c] = 2'd3; m_mode[c] = 3'd3; m_bcd[c] = 1'b0;
            m_wrhi[c] = 1'b0; m_rdhi[c] = 1'b0; m_hold[c] = 8'h00;
            m_clat[c] = 2'd0; m_lcnt[c] = 16'h0; m_spend[c] = 1'b0; m_sts[c] = 8'h00;
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; addr = 2'd0; wdata = 8'h00;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        model_reset();
    endtask

    // Expected read byte and the requirement it exercises
    task automatic model_read(int a, output logic [7:0] e, output string tg);
        if (a == 3) begin
            e = 8'h00; tg = "R1";
        end else if (m_spend[a]) begin
            e = m_sts[a]; m_spend[a] = 1'b0; tg = "R9";
        end else if (m_clat[a] != 2'd0) begin
            tg = "R6";
            case (m_clat[a])
                2'd1: begin e = m_lcnt[a][7:0];  m_clat[a] = 2'd0; end
                2'd2: begin e = m_lcnt[a][15:8]; m_clat[a] = 2'd0; end
                default: begin e = m_lcnt[a][7:0]; m_clat[a] = 2'd2; end
            endcase
        end else begin
            tg = "R5";
            case (m_acc[a])
                2'd2: e = live_of(a)[15:8];
                2'd3: begin
                    e = m_rdhi[a] ? live_of(a)[15:8] : live_of(a)[7:0];
                    m_rdhi[a] = !m_rdhi[a];
                end
                default: e = live_of(a)[7:0];
            endcase
        end
    endtask

    // Expected load mask and value after a write
    task automatic model_write(int a, logic [7:0] d, output logic [2:0] mask,
                               output logic [15:0] val, output string tg);
        mask = 3'b000; val = 16'h0;
        if (a == 3) begin
            int sel = int'(d[7:6]);
            if (sel == 3) begin
                tg = "R8";
                for (int c = 0; c < NCH; c++) begin
                    if (d[c+1]) begin
                        if (!d[5] && m_clat[c] == 2'd0) begin
                            m_lcnt[c] = live_of(c); m_clat[c] = m_acc[c];
                        end
                        if (!d[4] && !m_spend[c]) begin
                            m_sts[c] = {chan_out[c], 1'b0, m_acc[c], m_mode[c], m_bcd[c]};
                            m_spend[c] = 1'b1;
                        end
                    end
                end
            end else if (d[5:4] == 2'd0) begin
                tg = "R6";
                if (m_clat[sel] == 2'd0) begin
                    m_lcnt[sel] = live_of(sel); m_clat[sel] = m_acc[sel];
                end
            end else begin
                tg = "R2";
                m_acc[sel] = d[5:4]; m_mode[sel] = d[3:1]; m_bcd[sel] = d[0];
                m_wrhi[sel] = 1'b0; m_rdhi[sel] = 1'b0;
            end
        end else begin
            case (m_acc[a])
                2'd1: begin tg = "R4"; mask[a] = 1'b1; val = {8'h00, d}; end
                2'd2: begin tg = "R4"; mask[a] = 1'b1; val = {d, 8'h00}; end
                default: begin
                    tg = "R3";
                    if (m_wrhi[a]) begin mask[a] = 1'b1; val = {d, m_hold[a]}; end
                    else m_hold[a] = d;
                    m_wrhi[a] = !m_wrhi[a];
                end
            endcase
        end
    endtask

    task automatic do_read(int a, string ovr);
        logic [7:0] e;
        string tg;
        @(negedge clk);
        model_read(a, e, tg);
        addr = 2'(a); rd_en = 1'b1;
        @(posedge clk);
        @(negedge clk) rd_en = 1'b0;
        check((ovr != "") ? ovr : tg, 32'(rdata), 32'(e));
    endtask

    task automatic do_write(int a, logic [7:0] d, string ovr);
        logic [2:0]  mask;
        logic [15:0] val;
        string tg;
        @(negedge clk);
        model_write(a, d, mask, val, tg);
        addr = 2'(a); wdata = d; wr_en = 1'b1;
        @(posedge clk);
        @(negedge clk) wr_en = 1'b0;
        if (ovr != "") tg = ovr;
        check(tg, 32'(load_pulse), 32'(mask));
        if (mask != 3'b000) check(tg, 32'(load_value[a*16 +: 16]), 32'(val));
    endtask

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] keep;
        void'($urandom(32'h0005_eed5));
        live_count = {16'h0F0E, 16'hABCD, 16'h1234};
        chan_out   = 3'b101;
        do_reset();
        // R11: reset values at the ports
        check("R11", 32'(rdata), 32'h0);
        check("R11", 32'(load_pulse), 32'h0);
        // R11: word access starting at low byte
        do_read(1, "R11");
        do_read(1, "R11");
        do_read(1, "R5");
        // R1: control address reads zero
        do_read(3, "R1");
        // R2/R4: low-only on ch0, high-only on ch1
        do_write(3, 8'b00_01_010_0, "R2");
        do_write(0, 8'h5A, "R4");
        do_read(0, "R5");
        do_read(0, "R5");
        do_write(3, 8'b01_10_000_1, "R2");
        do_write(1, 8'hC3, "R4");
        do_read(1, "R5");
        // R3: word write on ch2
        do_write(2, 8'h11, "R3");
        do_write(2, 8'h22, "R3");
        // R6/R7: capture ch2, change live, second capture ignored
        do_write(3, 8'b10_00_0000, "R6");
        @(negedge clk) live_count[32 +: 16] = 16'h7788;
        do_write(3, 8'b10_00_0000, "R7");
        do_read(2, "R7");
        do_read(2, "R6");
        do_read(2, "R6");
        // R8/R9: read-back count and status for all channels
        do_write(3, 8'b11_00_1110, "R8");
        do_write(3, 8'b11_10_1110, "R7");
        for (int c = 0; c < NCH; c++) begin
            do_read(c, "R9");
            do_read(c, "R8");
        end
        // R10: rdata holds across writes and idle cycles
        keep = rdata;
        do_write(0, 8'h01, "");
        repeat (3) @(negedge clk);
        check("R10", 32'(rdata), 32'(keep));
        // Constrained random mix
        for (int i = 0; i < 3000; i++) begin
            int r = int'($urandom_range(9, 0));
            if (r < 2) begin
                @(negedge clk);
                live_count = {$urandom(), $urandom()};
                chan_out = 3'($urandom());
            end else if (r < 5) begin
                do_read(int'($urandom_range(3, 0)), "");
            end else begin
                do_write(int'($urandom_range(3, 0)), 8'($urandom()), "");
            end
        end
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule